// File: doc/BRIEF.md
# Platform Interrupt Controller Register File

This block is the register side of an interrupt controller for 32 platform sources. A host reaches it over a simple access port with a 12-bit byte address, a size code and 64-bit write data. Each register is 64 bits wide. Any aligned access of one, two, four or eight bytes reads or updates just the byte lanes it covers.

The block samples the source lines into a request register (IRR). Each source is level or edge sensitive, and its active level can be inverted. The block reports which requests are pending and not masked. When software changes mask bits, or clears edge-latched requests, the block queues assert and deassert events. These leave on a valid/ready output one per handshake, tagged with the source's programmable vector byte. Message delivery further downstream is not part of this block.

Register map (8-byte aligned base offsets): 0x000 identification, 0x008 mask, 0x010 edge select, 0x018 polarity, 0x020 message enable, 0x028 clear, 0x030 IRR, 0x038 in-service view, 0x040 and 0x048 automatic-control, 0x100–0x11F route bytes, 0x200–0x21F vector bytes.

Top module: `pic_regfile`

## Requirements
- R1: The access size code is 0/1/2/3 for 1/2/4/8 bytes. The register is picked by the address with its low three bits cleared, and those three bits give the starting byte. A write replaces only the bytes it covers and leaves all other bytes of the register unchanged.
- R2: A read returns the selected register shifted right by eight times the starting byte, with bytes above the access size forced to zero. The result appears on acc_rdata one cycle after the request and holds until the next read.
- R3: An access whose address is not a multiple of its size changes no state. A misaligned read returns zero.
- R4: After reset the mask (0x008) is all ones. Edge select, polarity, message enable and IRR are zero. Vector byte i holds i, and every route byte holds 0x01.
- R5: On a mask write, each source bit that changes from 1 to 0 queues an assert event (evt_assert=1). Each source bit that changes from 0 to 1 queues a deassert event (evt_assert=0).
- R6: A write to the clear register (0x028) removes IRR bits only where the written bit, the IRR bit and the edge-select bit are all 1. Each removed bit queues a deassert event. The clear register reads as zero.
- R7: The identification register (0x000) is read-only. It holds the controller ID in bits 31:24, the version in bits 39:32 and the source count minus one (31) in bits 55:48. All other bits are zero.
- R8: Route bytes (0x100–0x11F) always read 0x01. Writes to them and to the automatic-control registers (0x040, 0x048) are ignored, and the automatic-control registers read zero. Unmapped offsets read zero and ignore writes.
- R9: For a level-mode source (edge bit 0), the IRR bit equals the line XOR the polarity bit, one cycle later.
- R10: For an edge-mode source, the IRR bit sets on a rising edge of the line XOR polarity. It stays set until a clear removes it.
- R11: pend_out equals IRR AND NOT mask for sources 0–31. Offset 0x030 reads the IRR and 0x038 reads the same pending set, both zero-extended.
- R12: While any event is queued, evt_valid is high and presents the lowest-numbered queued source, its kind and its current vector byte. One event is removed per cycle with evt_ready high. A newer event for a source replaces the kind of one still queued.
- R13: Vector bytes (0x200–0x21F, one byte per source in source order) are writable with the same byte-lane rules as the other registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte address |
| acc_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| acc_wdata | input | 64 | Write data, right-aligned |
| acc_rdata | output | 64 | Read data, right-aligned, one cycle after the read |
| src_lines | input | 32 | Interrupt source lines |
| pend_out | output | 32 | Pending and unmasked sources |
| evt_valid | output | 1 | An event is offered |
| evt_ready | input | 1 | Consumer accepts the offered event |
| evt_assert | output | 1 | 1 = assert event, 0 = deassert event |
| evt_vector | output | 8 | Vector byte of the event's source |

## Verification
The bench aims at partial-lane writes that straddle the two 32-bit halves, and at misaligned accesses. A design that masked lanes wrongly would corrupt neighbouring bytes of the mask or vector table, or would let a misaligned write through. It then drives a clear at a level source and an edge source in the same write: a design without the edge qualification would drop a live level request. Events are held back with evt_ready low while two sources change, so an arbiter that picked the highest index or dropped held events would show the wrong vector. A free-running stretch of random lines, edge modes and ready stalls runs against the reference model, which catches polarity and rising-edge detection that are off by a cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int ACC_AW = 12;
   localparam int REG_W  = 64;

   localparam logic [ACC_AW-1:0] OFF_ID    = 12'h000;
   localparam logic [ACC_AW-1:0] OFF_MASK  = 12'h008;
   localparam logic [ACC_AW-1:0] OFF_EDGE  = 12'h010;
   localparam logic [ACC_AW-1:0] OFF_POL   = 12'h018;
   localparam logic [ACC_AW-1:0] OFF_MSGEN = 12'h020;
   localparam logic [ACC_AW-1:0] OFF_CLR   = 12'h028;
   localparam logic [ACC_AW-1:0] OFF_IRR   = 12'h030;
   localparam logic [ACC_AW-1:0] OFF_ISR   = 12'h038;
   localparam logic [ACC_AW-1:0] OFF_ROUTE = 12'h100;
   localparam logic [ACC_AW-1:0] OFF_VEC   = 12'h200;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;
endpackage

// File: rtl/pic_lane.sv
module pic_lane
   import pic_pkg::*;
(
   input  logic [ACC_AW-1:0] addr,
   input  logic [1:0]        size,
   input  logic [REG_W-1:0]  wdata,
   output logic              aligned,
   output logic [ACC_AW-1:0] base,
   output logic [2:0]        boff,
   output logic [REG_W-1:0]  size_mask,
   output logic [REG_W-1:0]  lane,
   output logic [REG_W-1:0]  wshift
);
   logic [2:0] amask;

   always_comb begin
      case (acc_size_e'(size))
         SZ_BYTE:  size_mask = 64'h0000_0000_0000_00FF;
         SZ_HALF:  size_mask = 64'h0000_0000_0000_FFFF;
         SZ_WORD:  size_mask = 64'h0000_0000_FFFF_FFFF;
         default:  size_mask = '1;
      endcase
      amask   = (3'd1 << size) - 3'd1;
      aligned = (addr[2:0] & amask) == 3'd0;
      boff    = addr[2:0];
      base    = {addr[ACC_AW-1:3], 3'b000};
      lane    = size_mask << {boff, 3'b000};
      wshift  = (wdata & size_mask) << {boff, 3'b000};
   end
endmodule

// File: rtl/pic_srclatch.sv
module pic_srclatch #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   input  logic [NSRC-1:0] edge_sel,
   input  logic [NSRC-1:0] pol,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] irr
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic act, prev_q, irr_q;
      assign act    = src[i] ^ pol[i];
      assign irr[i] = irr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            irr_q  <= 1'b0;
         end else begin
            prev_q <= act;
            if (edge_sel[i]) irr_q <= (irr_q & ~clr[i]) | (act & ~prev_q);
            else             irr_q <= act;
         end
      end

      AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
         !edge_sel[i] |=> irr[i] == $past(src[i] ^ pol[i])); // R9
      AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_sel[i] && irr[i] && !clr[i]) |=> irr[i]); // R10
   end
endmodule

// File: rtl/pic_evq.sv
module pic_evq #(
   parameter  int NSRC = 32,
   localparam int IW   = $clog2(NSRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_as,
   input  logic [NSRC-1:0] set_de,
   input  logic            evt_ready,
   output logic            evt_valid,
   output logic            evt_assert,
   output logic [IW-1:0]   evt_idx
);
   logic [NSRC-1:0] pend_q, kind_q, take_oh;
   logic [IW-1:0]   sel;

   always_comb begin
      sel = '0;
      for (int i = NSRC - 1; i >= 0; i--)
         if (pend_q[i]) sel = IW'(i);
   end

   assign evt_valid  = |pend_q;
   assign evt_assert = kind_q[sel];
   assign evt_idx    = sel;
   assign take_oh    = (evt_valid && evt_ready) ? (NSRC'(1) << sel) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         kind_q <= '0;
      end else begin
         pend_q <= (pend_q & ~take_oh) | set_as | set_de;
         kind_q <= (kind_q & ~set_de) | set_as;
      end
   end

   AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !evt_ready && set_as == '0 && set_de == '0)
      |=> (evt_valid && $stable(evt_idx) && $stable(evt_assert))); // R12
   AST_EVT_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      (set_as & set_de) == '0); // R5
endmodule

// File: rtl/pic_regfile.sv
module pic_regfile
   import pic_pkg::*;
#(
   parameter int         NUM_SRC  = 32,
   parameter logic [7:0] CTRL_ID  = 8'h07,
   parameter logic [7:0] CTRL_VER = 8'h01
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [11:0]        acc_addr,
   input  logic [1:0]         acc_size,
   input  logic [63:0]        acc_wdata,
   output logic [63:0]        acc_rdata,
   input  logic [NUM_SRC-1:0] src_lines,
   output logic [NUM_SRC-1:0] pend_out,
   output logic               evt_valid,
   input  logic               evt_ready,
   output logic               evt_assert,
   output logic [7:0]         evt_vector
);
   localparam int TBL_REGS = NUM_SRC / 8;
   localparam int IW       = $clog2(NUM_SRC);
   localparam logic [7:0]       NSRC_M1 = 8'(NUM_SRC - 1);
   localparam logic [REG_W-1:0] ID_VAL  =
      {8'h00, NSRC_M1, 8'h00, CTRL_VER, CTRL_ID, 24'h000000};

   if (NUM_SRC % 8 != 0 || NUM_SRC < 8 || NUM_SRC > 64) begin : g_bad_nsrc
      $error("NUM_SRC must be a multiple of 8 between 8 and 64");
   end

   logic              aligned;
   logic [ACC_AW-1:0] base;
   logic [2:0]        boff;
   logic [REG_W-1:0]  size_mask, lane, wshift;

   pic_lane u_lane (
      .addr(acc_addr), .size(acc_size), .wdata(acc_wdata),
      .aligned(aligned), .base(base), .boff(boff),
      .size_mask(size_mask), .lane(lane), .wshift(wshift)
   );

   logic [REG_W-1:0]   mask_q, edge_q, pol_q, msgen_q, mask_nxt, rval;
   logic [REG_W-1:0]   vec_q [TBL_REGS];
   logic [NUM_SRC-1:0] irr, clr_bits, ev_as, ev_de;
   logic [NUM_SRC*8-1:0] vec_flat;
   logic [IW-1:0]      evt_idx;
   logic               wr, rd, mask_wr, clr_wr;

   assign wr       = acc_valid && acc_write && aligned;
   assign rd       = acc_valid && !acc_write;
   assign mask_wr  = wr && base == OFF_MASK;
   assign clr_wr   = wr && base == OFF_CLR;
   assign mask_nxt = (mask_q & ~lane) | wshift;

   assign ev_as    = mask_wr ? (mask_q[NUM_SRC-1:0] & ~mask_nxt[NUM_SRC-1:0]) : '0;
   assign clr_bits = clr_wr ? (wshift[NUM_SRC-1:0] & irr & edge_q[NUM_SRC-1:0]) : '0;
   assign ev_de    = (mask_wr ? (~mask_q[NUM_SRC-1:0] & mask_nxt[NUM_SRC-1:0]) : '0)
                   | clr_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         edge_q  <= '0;
         pol_q   <= '0;
         msgen_q <= '0;
      end else if (wr) begin
         case (base)
            OFF_MASK:  mask_q  <= mask_nxt;
            OFF_EDGE:  edge_q  <= (edge_q & ~lane) | wshift;
            OFF_POL:   pol_q   <= (pol_q & ~lane) | wshift;
            OFF_MSGEN: msgen_q <= (msgen_q & ~lane) | wshift;
            default: ;
         endcase
      end
   end

   for (genvar k = 0; k < TBL_REGS; k++) begin : g_vec
      localparam logic [ACC_AW-1:0] VADDR = OFF_VEC + ACC_AW'(k * 8);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int j = 0; j < 8; j++) vec_q[k][8*j +: 8] <= 8'(k * 8 + j);
         end else if (wr && base == VADDR) begin
            vec_q[k] <= (vec_q[k] & ~lane) | wshift;
         end
      end
      assign vec_flat[64*k +: 64] = vec_q[k];
   end

   always_comb begin
      case (base)
         OFF_ID:    rval = ID_VAL;
         OFF_MASK:  rval = mask_q;
         OFF_EDGE:  rval = edge_q;
         OFF_POL:   rval = pol_q;
         OFF_MSGEN: rval = msgen_q;
         OFF_IRR:   rval = REG_W'(irr);
         OFF_ISR:   rval = REG_W'(pend_out);
         default:   rval = '0;
      endcase
      for (int k = 0; k < TBL_REGS; k++) begin
         if (base == OFF_VEC + ACC_AW'(k * 8))   rval = vec_q[k];
         if (base == OFF_ROUTE + ACC_AW'(k * 8)) rval = {8{8'h01}};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_rdata <= '0;
      else if (rd)  acc_rdata <= aligned ? ((rval >> {boff, 3'b000}) & size_mask) : '0;
   end

   pic_srclatch #(.NSRC(NUM_SRC)) u_latch (
      .clk(clk), .rst_n(rst_n), .src(src_lines),
      .edge_sel(edge_q[NUM_SRC-1:0]), .pol(pol_q[NUM_SRC-1:0]),
      .clr(clr_bits), .irr(irr)
   );

   assign pend_out = irr & ~mask_q[NUM_SRC-1:0];

   pic_evq #(.NSRC(NUM_SRC)) u_evq (
      .clk(clk), .rst_n(rst_n), .set_as(ev_as), .set_de(ev_de),
      .evt_ready(evt_ready), .evt_valid(evt_valid),
      .evt_assert(evt_assert), .evt_idx(evt_idx)
   );

   assign evt_vector = vec_flat[{evt_idx, 3'b000} +: 8];

   AST_MISALIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !aligned)
      |=> ($stable(mask_q) && $stable(edge_q) && $stable(pol_q) && $stable(msgen_q))); // R3
   AST_LANES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> ((mask_q & ~$past(lane)) == ($past(mask_q) & ~$past(lane)))); // R1
   AST_CLEAR_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !edge_q[0] && irr[0] && (src_lines[0] ^ pol_q[0])) |=> irr[0]); // R6
endmodule

// File: tb/test_pic_regfile.sv
module test_pic_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [11:0] acc_addr = '0;
   logic [1:0]  acc_size = '0;
   logic [63:0] acc_wdata = '0;
   logic [63:0] acc_rdata;
   logic [31:0] src = '0;
   logic [31:0] pend_out;
   logic        evt_valid, evt_assert;
   logic        evt_ready = 1'b0;
   logic [7:0]  evt_vector;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pic_regfile i_pic_regfile (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .src_lines(src), .pend_out(pend_out),
      .evt_valid(evt_valid), .evt_ready(evt_ready),
      .evt_assert(evt_assert), .evt_vector(evt_vector)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [63:0] m_mask, m_edge, m_pol, m_msg, m_rd, o_edge, m_nv, m_rv;
   logic [31:0] m_irr, m_prev, m_pend, m_kind, m_act, m_as, m_de, m_clr;
   logic [7:0]  m_vec [32];
   int m_sel, m_nb, m_off, m_base, c_sel;

   function automatic logic [63:0] m_val(int b);
      logic [63:0] v = '0;
      if (b == 0)       v = 64'h001F_0001_0700_0000;
      else if (b == 8)  v = m_mask;
      else if (b == 16) v = m_edge;
      else if (b == 24) v = m_pol;
      else if (b == 32) v = m_msg;
      else if (b == 48) v = {32'h0, m_irr};
      else if (b == 56) v = {32'h0, m_irr & ~m_mask[31:0]};
      else if (b >= 256 && b < 288) v = 64'h0101_0101_0101_0101;
      else if (b >= 512 && b < 544)
         for (int j = 0; j < 8; j++) v[8*j +: 8] = m_vec[b - 512 + j];
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mask = '1; m_edge = '0; m_pol = '0; m_msg = '0; m_rd = '0;
         m_irr = '0; m_prev = '0; m_pend = '0; m_kind = '0;
         for (int i = 0; i < 32; i++) m_vec[i] = 8'(i);
      end else begin
         o_edge = m_edge;
         m_act = src ^ m_pol[31:0];
         m_as = '0; m_de = '0; m_clr = '0;
         m_sel = -1;
         for (int i = 0; i < 32; i++) if (m_pend[i] && m_sel < 0) m_sel = i;
         if (acc_valid) begin
            m_nb = 1 << acc_size;
            m_off = int'(acc_addr) % 8;
            m_base = int'(acc_addr) - m_off;
            if (int'(acc_addr) % m_nb != 0) begin
               if (!acc_write) m_rd = '0;
            end else if (!acc_write) begin
               m_rv = m_val(m_base);
               m_rd = '0;
               for (int b = 0; b < m_nb; b++) m_rd[8*b +: 8] = m_rv[8*(m_off+b) +: 8];
            end else begin
               if (m_base == 8)       m_nv = m_mask;
               else if (m_base == 16) m_nv = m_edge;
               else if (m_base == 24) m_nv = m_pol;
               else if (m_base == 32) m_nv = m_msg;
               else                   m_nv = '0;
               for (int b = 0; b < m_nb; b++) m_nv[8*(m_off+b) +: 8] = acc_wdata[8*b +: 8];
               if (m_base == 8) begin
                  for (int i = 0; i < 32; i++) begin
                     if (m_mask[i] && !m_nv[i]) m_as[i] = 1'b1;
                     if (!m_mask[i] && m_nv[i]) m_de[i] = 1'b1;
                  end
                  m_mask = m_nv;
               end
               else if (m_base == 16) m_edge = m_nv;
               else if (m_base == 24) m_pol = m_nv;
               else if (m_base == 32) m_msg = m_nv;
               else if (m_base == 40) begin
                  for (int i = 0; i < 32; i++)
                     if (m_nv[i] && m_irr[i] && m_edge[i]) begin
                        m_clr[i] = 1'b1; m_de[i] = 1'b1;
                     end
               end else if (m_base >= 512 && m_base < 544) begin
                  for (int b = 0; b < m_nb; b++)
                     m_vec[m_base - 512 + m_off + b] = acc_wdata[8*b +: 8];
               end
            end
         end
         for (int i = 0; i < 32; i++) begin
            if (o_edge[i]) m_irr[i] = (m_irr[i] && !m_clr[i]) || (m_act[i] && !m_prev[i]);
            else           m_irr[i] = m_act[i];
         end
         m_prev = m_act;
         if (m_sel >= 0 && evt_ready) m_pend[m_sel] = 1'b0;
         for (int i = 0; i < 32; i++) begin
            if (m_as[i]) begin m_pend[i] = 1'b1; m_kind[i] = 1'b1; end
            if (m_de[i]) begin m_pend[i] = 1'b1; m_kind[i] = 1'b0; end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 rdata vs model", acc_rdata, m_rd);
         chk("R11 pend_out vs model", 64'(pend_out), 64'(m_irr & ~m_mask[31:0]));
         chk("R12 evt_valid vs model", 64'(evt_valid), 64'(|m_pend));
         if (|m_pend) begin
            c_sel = 0;
            for (int i = 31; i >= 0; i--) if (m_pend[i]) c_sel = i;
            chk("R12 evt_vector vs model", 64'(evt_vector), 64'(m_vec[c_sel]));
            chk("R5 evt_assert vs model", 64'(evt_assert), 64'(m_kind[c_sel]));
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input logic [11:0] a, input logic [1:0] s, input logic [63:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = s; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [1:0] s, output logic [63:0] v);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = s;
      @(negedge clk);
      v = acc_rdata;
      acc_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [63:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      rd(12'h000, 2'd3, v); chk("R7 id value", v, 64'h001F_0001_0700_0000);
      rd(12'h008, 2'd3, v); chk("R4 mask reset", v, '1);
      rd(12'h200, 2'd3, v); chk("R4 vector reset low", v, 64'h0706_0504_0302_0100);
      rd(12'h218, 2'd3, v); chk("R4 vector reset high", v, 64'h1F1E_1D1C_1B1A_1918);
      rd(12'h108, 2'd2, v); chk("R4 route reset", v, 64'h0101_0101);
      rd(12'h030, 2'd3, v); chk("R4 irr reset", v, 64'h0);
      rd(12'h040, 2'd3, v); chk("R8 autoctl reads zero", v, 64'h0);

      wr(12'h00A, 2'd2, 64'h0);
      rd(12'h008, 2'd3, v); chk("R3 misaligned write ignored", v, '1);

      wr(12'h00A, 2'd1, 64'h0);
      chk("R5 assert event offered", 64'(evt_valid), 64'd1);
      chk("R12 lowest source first", 64'(evt_vector), 64'd16);
      chk("R5 event kind assert", 64'(evt_assert), 64'd1);
      rd(12'h008, 2'd3, v); chk("R1 halfword lanes only", v, 64'hFFFF_FFFF_0000_FFFF);
      evt_ready = 1'b1;
      idle(20);
      chk("R12 queue drained", 64'(evt_valid), 64'd0);

      wr(12'h00C, 2'd2, 64'h0);
      wr(12'h008, 2'd2, 64'h0);
      idle(20);
      rd(12'h008, 2'd3, v); chk("R1 word writes", v, 64'h0);

      wr(12'h202, 2'd0, 64'hA5);
      rd(12'h200, 2'd3, v); chk("R13 vector byte write", v, 64'h0706_0504_03A5_0100);
      rd(12'h202, 2'd0, v); chk("R2 byte read", v, 64'hA5);
      rd(12'h204, 2'd1, v); chk("R2 halfword read shifted", v, 64'h0504);
      rd(12'h201, 2'd1, v); chk("R3 misaligned read zero", v, 64'h0);

      wr(12'h000, 2'd3, '1);
      rd(12'h000, 2'd3, v); chk("R7 id read-only", v, 64'h001F_0001_0700_0000);
      wr(12'h100, 2'd3, 64'h0);
      rd(12'h100, 2'd3, v); chk("R8 route write ignored", v, 64'h0101_0101_0101_0101);
      wr(12'h040, 2'd3, '1);
      rd(12'h040, 2'd3, v); chk("R8 autoctl write ignored", v, 64'h0);
      wr(12'h300, 2'd3, '1);
      rd(12'h300, 2'd3, v); chk("R8 unmapped reads zero", v, 64'h0);

      src[3] = 1'b1;
      idle(2);
      rd(12'h030, 2'd3, v); chk("R9 level source latched", v, 64'h8);
      chk("R11 pend_out level", 64'(pend_out), 64'h8);
      rd(12'h038, 2'd3, v); chk("R11 pending view", v, 64'h8);
      wr(12'h008, 2'd0, 64'h08);
      chk("R5 deassert on mask", 64'(evt_assert), 64'd0);
      chk("R11 masked not pending", 64'(pend_out), 64'h0);
      wr(12'h008, 2'd0, 64'h00);
      src[3] = 1'b0;
      idle(2);
      rd(12'h030, 2'd3, v); chk("R9 level source drops", v, 64'h0);

      wr(12'h018, 2'd0, 64'h20);
      idle(1);
      chk("R9 inverted polarity", 64'(pend_out), 64'h20);
      wr(12'h018, 2'd0, 64'h00);
      idle(1);

      wr(12'h011, 2'd0, 64'h01);
      src[8] = 1'b1; idle(1); src[8] = 1'b0;
      idle(3);
      rd(12'h030, 2'd3, v); chk("R10 edge request held", v, 64'h100);
      src[3] = 1'b1;
      idle(2);
      wr(12'h028, 2'd3, 64'h108);
      chk("R6 clear hits edge source only", 64'(pend_out), 64'h008);
      chk("R6 clear deassert event", 64'(evt_vector), 64'd8);
      chk("R6 clear event kind", 64'(evt_assert), 64'd0);
      rd(12'h028, 2'd3, v); chk("R6 clear reads zero", v, 64'h0);
      src[3] = 1'b0;
      idle(4);

      evt_ready = 1'b0;
      wr(12'h008, 2'd2, 64'h0010_0200);
      idle(2);
      chk("R12 held lowest first", 64'(evt_vector), 64'd9);
      evt_ready = 1'b1;
      @(negedge clk);
      chk("R12 next source", 64'(evt_vector), 64'd20);
      evt_ready = 1'b0;
      wr(12'h008, 2'd2, 64'h0);
      chk("R12 newer kind replaces", 64'(evt_assert), 64'd1);
      evt_ready = 1'b1;
      idle(4);

      wr(12'h010, 2'd2, 64'h00FF_00F0);
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         src = $urandom;
         evt_ready = ($urandom % 4) != 0;
         if (n % 37 == 0) wr(12'h028, 2'd2, 64'(32'($urandom)));
         if (n % 53 == 0) wr(12'h008, 2'd1, 64'(16'($urandom)));
         if (n % 71 == 0) wr(12'h018, 2'd0, 64'(8'($urandom)));
      end
      evt_ready = 1'b1;
      idle(40);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule